// File: doc/BRIEF.md
# Stackable Scan Line Switch Sequencer

This block drives the sixteen row-select switches of one slice of an LED matrix driver. A slice can run on its own, or it can sit in a stack of two or three slices that together scan a taller matrix. A global line index moves forward by one on each line-advance pulse and returns to zero on a frame-start pulse. Each slice decides from its stack position and the module-size code whether it owns the current line. If it owns the line, it turns on exactly one of its switches.

A slice mounted rotated by 180 degrees can reverse its switch order, so the physical scan still runs from the top line to the bottom line. A programmable active-line count shortens the frame. The index wraps after the last active line, so the unused switches at the tail of the scan order never turn on. The output is registered and is updated only on the clock edge that takes in a line-advance or frame-start pulse.

Top module: `scan_line_sequencer`

## Requirements
- R1: While rst_n is low, and after reset until the first line_adv or frame_start is taken in, ls_en is all zero.
- R2: On the edge where frame_start is high, the global index becomes 0, even if line_adv is also high. ls_en then shows the decode of line 0.
- R3: On an edge with line_adv high and frame_start low, the index goes up by one. After the effective count minus one it wraps to 0. The effective count is line_count, except that a line_count of 0 or above 32 counts as 32.
- R4: For mod_size codes 00, 10 and 11, the slice at slice_pos 0 owns lines 0 to 15, and line k turns on ls_en bit k whatever scan_rev is.
- R5: For mod_size codes 00, 10 and 11 with scan_rev 0, the slice at slice_pos 1 owns lines 16 to 31, and line 16+k turns on ls_en bit k.
- R6: For mod_size codes 00, 10 and 11 with scan_rev 1, the slice at slice_pos 1 turns on ls_en bit 15−k for line 16+k. Line 16 uses bit 15 and line 31 uses bit 0.
- R7: With mod_size 11, the slice at slice_pos 2 never turns on a switch. A slice at slice_pos 2 or 3 never turns on a switch in any stacked code.
- R8: With mod_size 01, every slice works alone. Lines 0 to 15 turn on bit k for line k, lines 16 to 31 turn on nothing, and scan_rev has no effect.
- R9: At most one bit of ls_en is high at any time.
- R10: ls_en changes only on an edge where line_adv or frame_start was high.
- R11: Lines at or beyond the effective count are never lit. For example, with 30 lines the second slice never lights bits 14 and 15 when scan_rev is 0, and never lights bits 1 and 0 when scan_rev is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_adv | input | 1 | One-cycle pulse that advances the global line index |
| frame_start | input | 1 | One-cycle pulse that restarts the scan at line 0 |
| slice_pos | input | 2 | Position of this slice in the stack (0, 1 or 2) |
| mod_size | input | 2 | Stack arrangement code: 01 standalone, 00/10 two slices, 11 three slices |
| scan_rev | input | 1 | Reverse the switch order of the second slice |
| line_count | input | 6 | Number of active lines, 1 to 32 (0 or above 32 means 32) |
| ls_en | output | 16 | Line switch enables, one-hot or all zero |

## Verification
The assertions assume that slice_pos, mod_size, scan_rev and line_count stay constant between resets. ls_en holds a decode made under the settings in force at the last pulse, so changing a setting while running would leave a stale but legal value that the ownership and range checks would flag. The stimulus applies each configuration only inside a fresh reset window. It drives line_adv and frame_start as single-cycle pulses on the falling clock edge. The bench sweeps every stack position, mode code and reversal setting across several line counts, including 0, 1, 16, 17, 30, 32 and an over-range value.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    MS_PAIR_A = 2'b00,
    MS_SOLO   = 2'b01,
    MS_PAIR_B = 2'b10,
    MS_TRIO   = 2'b11
  } mod_size_e;

  typedef enum logic [1:0] {
    POS_TOP  = 2'd0,
    POS_LOW  = 2'd1,
    POS_DATA = 2'd2,
    POS_NONE = 2'd3
  } slice_pos_e;
endpackage

// File: rtl/scan_line_counter.sv
module scan_line_counter #(
  parameter int MAX_LINES = 32,
  localparam int IDX_W = $clog2(MAX_LINES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_adv,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] line_count,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_nxt,
  output logic             evt,
  output logic             wrap_hit,
  output logic             in_use
);
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] lc);
    if (lc == '0 || lc > CNT_W'(MAX_LINES)) return CNT_W'(MAX_LINES);
    return lc;
  endfunction

  logic [CNT_W-1:0] eff;
  logic             at_last;

  assign eff      = eff_count(line_count);
  assign at_last  = {1'b0, idx_q} >= CNT_W'(eff - 1'b1);
  assign evt      = line_adv | frame_start;
  assign wrap_hit = line_adv & ~frame_start & at_last;

  always_comb begin
    idx_nxt = idx_q;
    if (frame_start)   idx_nxt = '0;
    else if (line_adv) idx_nxt = at_last ? '0 : IDX_W'(idx_q + 1'b1);
  end

  assign in_use = {1'b0, idx_nxt} < eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (evt) idx_q <= idx_nxt;
  end
endmodule

// File: rtl/scan_slice_owner.sv
module scan_slice_owner
  import scan_seq_pkg::*;
#(
  parameter int SW_N = 16,
  localparam int IDX_W = $clog2(2 * SW_N),
  localparam int LOC_W = $clog2(SW_N)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       slice_pos,
  input  logic [1:0]       mod_size,
  input  logic             scan_rev,
  output logic             own_hit,
  output logic [LOC_W-1:0] local_sel
);
  function automatic logic [LOC_W-1:0] mirror(input logic [LOC_W-1:0] k);
    return LOC_W'(SW_N - 1) - k;
  endfunction

  logic             upper;
  logic [LOC_W-1:0] lo;

  assign upper = idx >= IDX_W'(SW_N);
  assign lo    = LOC_W'(upper ? idx - IDX_W'(SW_N) : idx);

  always_comb begin
    own_hit   = 1'b0;
    local_sel = lo;
    if (mod_size_e'(mod_size) == MS_SOLO) begin
      own_hit = ~upper;
    end else begin
      unique case (slice_pos_e'(slice_pos))
        POS_TOP: own_hit = ~upper;
        POS_LOW: begin
          own_hit   = upper;
          local_sel = scan_rev ? mirror(lo) : lo;
        end
        default: own_hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/scan_onehot_drv.sv
module scan_onehot_drv #(
  parameter int SW_N = 16,
  localparam int LOC_W = $clog2(SW_N)
) (
  input  logic             enable,
  input  logic [LOC_W-1:0] sel,
  output logic [SW_N-1:0]  sw_d
);
  for (genvar i = 0; i < SW_N; i++) begin : g_sw
    assign sw_d[i] = enable && (sel == LOC_W'(i));
  end
endmodule

// File: rtl/scan_line_sequencer.sv
module scan_line_sequencer #(
  parameter int SW_N = 16,
  localparam int MAX_LINES = 2 * SW_N,
  localparam int IDX_W = $clog2(MAX_LINES),
  localparam int CNT_W = IDX_W + 1,
  localparam int LOC_W = $clog2(SW_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_adv,
  input  logic             frame_start,
  input  logic [1:0]       slice_pos,
  input  logic [1:0]       mod_size,
  input  logic             scan_rev,
  input  logic [CNT_W-1:0] line_count,
  output logic [SW_N-1:0]  ls_en
);
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             evt, wrap_hit, in_use;
  logic             own_hit;
  logic [LOC_W-1:0] local_sel;
  logic [SW_N-1:0]  sw_d;

  scan_line_counter #(.MAX_LINES(MAX_LINES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .line_adv(line_adv), .frame_start(frame_start),
    .line_count(line_count), .idx_q(idx_q), .idx_nxt(idx_nxt), .evt(evt),
    .wrap_hit(wrap_hit), .in_use(in_use)
  );

  scan_slice_owner #(.SW_N(SW_N)) u_own (
    .idx(idx_nxt), .slice_pos(slice_pos), .mod_size(mod_size),
    .scan_rev(scan_rev), .own_hit(own_hit), .local_sel(local_sel)
  );

  scan_onehot_drv #(.SW_N(SW_N)) u_drv (
    .enable(own_hit & in_use), .sel(local_sel), .sw_d(sw_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ls_en <= '0;
    else if (evt) ls_en <= sw_d;
  end
endmodule

// File: rtl/scan_line_sequencer_chk.sv
module scan_line_sequencer_chk #(
  parameter int SW_N = 16,
  localparam int MAX_LINES = 2 * SW_N,
  localparam int IDX_W = $clog2(MAX_LINES),
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_adv,
  input logic             frame_start,
  input logic [1:0]       slice_pos,
  input logic [1:0]       mod_size,
  input logic [CNT_W-1:0] line_count,
  input logic [SW_N-1:0]  ls_en,
  input logic [IDX_W-1:0] line_idx,
  input logic             wrap_hit
);
  logic past_ok;
  logic [CNT_W-1:0] lim;

  assign lim = (line_count == '0 || line_count > CNT_W'(MAX_LINES)) ? CNT_W'(MAX_LINES) : line_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_zero_R1: assert (ls_en == '0);
  end

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ls_en));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(line_adv) && !$past(frame_start) |-> $stable(ls_en));

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> line_idx == '0);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |=> line_idx == '0);

  assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, line_idx} < lim);

  assert_silent_slice_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_size != 2'b01 && slice_pos[1]) |-> ls_en == '0);
endmodule

bind scan_line_sequencer scan_line_sequencer_chk #(.SW_N(SW_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_adv(line_adv), .frame_start(frame_start),
  .slice_pos(slice_pos), .mod_size(mod_size), .line_count(line_count),
  .ls_en(ls_en), .line_idx(idx_q), .wrap_hit(wrap_hit)
);

// File: tb/scan_line_sequencer_tb.sv
`timescale 1ns/1ps
module scan_line_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_adv = 1'b0;
  logic        frame_start = 1'b0;
  logic [1:0]  slice_pos = '0;
  logic [1:0]  mod_size = '0;
  logic        scan_rev = 1'b0;
  logic [5:0]  line_count = 6'd32;
  logic [15:0] ls_en;

  int checks = 0;
  int failures = 0;
  int cur_idx = 0;
  logic [15:0] seen, seen_exp;

  always #4 clk = ~clk;

  scan_line_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .line_adv(line_adv), .frame_start(frame_start),
    .slice_pos(slice_pos), .mod_size(mod_size), .scan_rev(scan_rev),
    .line_count(line_count), .ls_en(ls_en)
  );

  function automatic int eff_n(input int lc);
    return (lc == 0 || lc > 32) ? 32 : lc;
  endfunction

  function automatic logic [15:0] expect_ls(input int idx, input int pos,
                                            input int ms, input int rev);
    if (ms == 1) return (idx < 16) ? 16'(1 << idx) : 16'h0;    // R8
    if (pos == 0) return (idx < 16) ? 16'(1 << idx) : 16'h0;   // R4
    if (pos == 1 && idx >= 16)                                  // R5, R6
      return rev ? 16'(1 << (31 - idx)) : 16'(1 << (idx - 16));
    return 16'h0;                                               // R7
  endfunction

  function automatic string tag_for(input int pos, input int ms, input int rev);
    if (ms == 1) return "R8";
    if (pos == 0) return "R4";
    if (pos == 1) return rev ? "R6" : "R5";
    return "R7";
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (pos=%0d ms=%0d rev=%0d cnt=%0d idx=%0d)",
               req, act, exp, slice_pos, mod_size, scan_rev, line_count, cur_idx);
    end
  endtask

  task automatic pulse(input logic adv, input logic fs);
    @(negedge clk);
    line_adv = adv;
    frame_start = fs;
    @(negedge clk);
    line_adv = 1'b0;
    frame_start = 1'b0;
  endtask

  task automatic run_cfg(input int pos, input int ms, input int rev, input int lc);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    slice_pos = 2'(pos);
    mod_size = 2'(ms);
    scan_rev = rev[0];
    line_count = 6'(lc);
    @(negedge clk);
    chk("R1 reset", ls_en, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", ls_en, 16'h0);
    n = eff_n(lc);
    seen = '0;
    seen_exp = '0;
    pulse(1'b0, 1'b1);
    cur_idx = 0;
    chk({tag_for(pos, ms, rev), " R2 frame start"}, ls_en, expect_ls(0, pos, ms, rev));
    for (int s = 0; s < 2 * n + 1; s++) begin
      pulse(1'b1, 1'b0);
      cur_idx = (cur_idx + 1 >= n) ? 0 : cur_idx + 1;
      chk({tag_for(pos, ms, rev), " R3 step"}, ls_en, expect_ls(cur_idx, pos, ms, rev));
      chk("R9 onehot", 16'($countones(ls_en) > 1), 16'h0);
      seen = seen | ls_en;
      seen_exp = seen_exp | expect_ls(cur_idx, pos, ms, rev);
    end
    chk("R11 unused tail switches", seen, seen_exp);
    repeat (3) @(negedge clk);
    chk("R10 hold without pulse", ls_en, expect_ls(cur_idx, pos, ms, rev));
    pulse(1'b1, 1'b1);
    cur_idx = 0;
    chk("R2 frame start wins over advance", ls_en, expect_ls(0, pos, ms, rev));
  endtask

  initial begin
    int counts[7] = '{32, 30, 17, 16, 1, 0, 40};
    rst_n = 1'b1;
    #3 rst_n = 1'b0;
    @(negedge clk);
    chk("R1 in reset", ls_en, 16'h0);
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 2; r++)
          for (int c = 0; c < 7; c++)
            run_cfg(p, m, r, counts[c]);
    // R11 explicit tail cases with 30 lines on the second slice
    run_cfg(1, 0, 0, 30);
    chk("R11 rev0 bits 15:14 off", seen & 16'hC000, 16'h0);
    run_cfg(1, 0, 1, 30);
    chk("R11 rev1 bits 1:0 off", seen & 16'h0003, 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule